// File: doc/BRIEF.md
# Signed Sample to BCD Digits

This block accepts a 16-bit sensor word, of which only the ten least significant bits carry information. Those ten bits are read as a two's-complement sample. The block takes the sample's magnitude, multiplies it by four, and presents that product as four binary-coded decimal digits. A separate flag shows whether the sample was negative. The ten-bit field is also driven out, so that any observer can relate each reading to the code that produced it.

The code with only the sign bit set is the most negative value. It has no positive counterpart in ten bits, so the block shows it as zero with the sign flag low. The conversion logic is combinational. A parameter adds one output register stage, and that stage is on by default. The registered stage clears to zero on an asynchronous active-low reset. A downstream display driver or logger can use the digits directly, without any arithmetic of its own.

Top module: `signed_sample_bcd`

## Requirements
- R1: Input bits [15:10] have no effect on any output. Two words with equal bits [9:0] give identical outputs.
- R2: `sample_field` equals input bits [9:0] of the word that was registered.
- R3: When bit 9 of the sample is 0, the decimal value 1000·thousands + 100·hundreds + 10·tens + ones equals 4 × code, and `mag_negative` is 0.
- R4: When bit 9 is 1 and the code is above 512, the decimal value equals 4 × (1024 − code), which is the same as 2048 − 4 × (code − 512). In this case `mag_negative` is 1.
- R5: Code 512 (binary 10_0000_0000) sets all four digits to 0 and `mag_negative` to 0.
- R6: Every digit is in the range 0 to 9, and the thousands digit never exceeds 2. The largest value shown is 2044.
- R7: With the default register stage, outputs take their new values at the first rising clock edge after the input changes, and they hold their old values until that edge.
- R8: While `rst_n` is low, every output is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the output register stage |
| rst_n | input | 1 | Asynchronous active-low reset |
| sensor_word | input | 16 | Raw sensor word; only bits [9:0] are used |
| sample_field | output | 10 | The trimmed ten-bit sample |
| bcd_ones | output | 4 | Units digit |
| bcd_tens | output | 4 | Tens digit |
| bcd_hundreds | output | 4 | Hundreds digit |
| bcd_thousands | output | 4 | Thousands digit |
| mag_negative | output | 1 | High for a negative sample other than code 512 |

## Verification
The assertions assume that `sensor_word` is stable around each rising clock edge. Under that assumption, the registered field and the registered digits always come from the same word. The one-cycle tracking check compares against the input sampled at the previous edge. The bench respects this by changing the input only on falling clock edges. It also keeps `rst_n` low for several whole cycles before releasing it on a falling edge, so no edge ever samples a half-changed word.

// File: rtl/sbcd_pkg.sv
package sbcd_pkg;

    // Four decimal digits: ones, tens, hundreds, thousands.
    localparam int DIGITS    = 4;
    localparam int DIGIT_W   = 4;
    localparam int DIGITS_W  = DIGITS * DIGIT_W;

    typedef logic [DIGIT_W-1:0] bcd_digit_t;

    // Positions of each digit inside the packed digit bus.
    localparam int POS_ONES      = 0;
    localparam int POS_TENS      = 1;
    localparam int POS_HUNDREDS  = 2;
    localparam int POS_THOUSANDS = 3;

endpackage

// File: rtl/sbcd_magnitude.sv
module sbcd_magnitude #(
    parameter int SAMPLE_W    = 10,
    parameter int SCALE_SHIFT = 2,
    parameter int MAG_W       = SAMPLE_W + SCALE_SHIFT
) (
    input  logic [SAMPLE_W-1:0] sample,
    output logic                negative,
    output logic [MAG_W-1:0]    scaled
);

    logic                sign_bit;
    logic                min_code;
    logic [SAMPLE_W-1:0] magnitude;

    assign sign_bit = sample[SAMPLE_W-1];
    assign min_code = sign_bit & ~|sample[SAMPLE_W-2:0];

    always_comb begin
        if (min_code) begin
            magnitude = '0;
        end else if (sign_bit) begin
            magnitude = ~sample + 1'b1;
        end else begin
            magnitude = sample;
        end
    end

    // A zero reading is never signed.
    assign negative = sign_bit & ~min_code;
    assign scaled   = {magnitude, {SCALE_SHIFT{1'b0}}};

endmodule

// File: rtl/sbcd_dabble.sv
module sbcd_dabble
    import sbcd_pkg::*;
#(
    parameter int BIN_W = 12
) (
    input  logic [BIN_W-1:0]    bin_in,
    output logic [DIGITS_W-1:0] bcd_out
);

    localparam int TOT_W = DIGITS_W + BIN_W;

    logic [TOT_W-1:0] chain [BIN_W+1];
    logic             unused_tail;

    assign chain[0] = {{DIGITS_W{1'b0}}, bin_in};

    for (genvar s = 0; s < BIN_W; s++) begin : g_stage
        logic [DIGITS_W-1:0] dig_adj;
        for (genvar d = 0; d < DIGITS; d++) begin : g_digit
            bcd_digit_t nib;
            assign nib = chain[s][BIN_W + DIGIT_W*d +: DIGIT_W];
            assign dig_adj[DIGIT_W*d +: DIGIT_W] =
                (nib >= 4'd5) ? nib + 4'd3 : nib;
        end
        assign chain[s+1] = {dig_adj, chain[s][BIN_W-1:0]} << 1;
    end

    assign bcd_out     = chain[BIN_W][TOT_W-1 -: DIGITS_W];
    assign unused_tail = ^chain[BIN_W][BIN_W-1:0];

endmodule

// File: rtl/sbcd_out_stage.sv
module sbcd_out_stage #(
    parameter int W          = 27,
    parameter bit REGISTERED = 1'b1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d_in,
    output logic [W-1:0] q_out
);

    if (REGISTERED) begin : g_reg
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                q_out <= '0;
            end else begin
                q_out <= d_in;
            end
        end
    end else begin : g_wire
        assign q_out = d_in;
    end

endmodule

// File: rtl/signed_sample_bcd.sv
module signed_sample_bcd
    import sbcd_pkg::*;
#(
    parameter int IN_W        = 16,
    parameter int SAMPLE_W    = 10,
    parameter int SCALE_SHIFT = 2,
    parameter bit OUT_REG     = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IN_W-1:0]     sensor_word,
    output logic [SAMPLE_W-1:0] sample_field,
    output logic [3:0]          bcd_ones,
    output logic [3:0]          bcd_tens,
    output logic [3:0]          bcd_hundreds,
    output logic [3:0]          bcd_thousands,
    output logic                mag_negative
);

    localparam int MAG_W  = SAMPLE_W + SCALE_SHIFT;
    localparam int PACK_W = SAMPLE_W + 1 + DIGITS_W;

    logic [SAMPLE_W-1:0] sample_c;
    logic                neg_c;
    logic [MAG_W-1:0]    scaled_c;
    logic [DIGITS_W-1:0] digits_c;
    logic [PACK_W-1:0]   pack_c;
    logic [PACK_W-1:0]   pack_q;
    logic [DIGITS_W-1:0] digits_q;
    logic                unused_upper_bits;

    assign sample_c          = sensor_word[SAMPLE_W-1:0];
    assign unused_upper_bits = ^sensor_word[IN_W-1:SAMPLE_W];

    sbcd_magnitude #(
        .SAMPLE_W   (SAMPLE_W),
        .SCALE_SHIFT(SCALE_SHIFT),
        .MAG_W      (MAG_W)
    ) u_mag (
        .sample  (sample_c),
        .negative(neg_c),
        .scaled  (scaled_c)
    );

    sbcd_dabble #(
        .BIN_W(MAG_W)
    ) u_dabble (
        .bin_in (scaled_c),
        .bcd_out(digits_c)
    );

    assign pack_c = {sample_c, neg_c, digits_c};

    sbcd_out_stage #(
        .W         (PACK_W),
        .REGISTERED(OUT_REG)
    ) u_out (
        .clk  (clk),
        .rst_n(rst_n),
        .d_in (pack_c),
        .q_out(pack_q)
    );

    assign sample_field  = pack_q[PACK_W-1 -: SAMPLE_W];
    assign mag_negative  = pack_q[DIGITS_W];
    assign digits_q      = pack_q[DIGITS_W-1:0];
    assign bcd_ones      = digits_q[DIGIT_W*POS_ONES      +: DIGIT_W];
    assign bcd_tens      = digits_q[DIGIT_W*POS_TENS      +: DIGIT_W];
    assign bcd_hundreds  = digits_q[DIGIT_W*POS_HUNDREDS  +: DIGIT_W];
    assign bcd_thousands = digits_q[DIGIT_W*POS_THOUSANDS +: DIGIT_W];

endmodule

// File: rtl/signed_sample_bcd_chk.sv
module signed_sample_bcd_chk #(
    parameter int IN_W        = 16,
    parameter int SAMPLE_W    = 10,
    parameter int SCALE_SHIFT = 2,
    parameter bit OUT_REG     = 1'b1
) (
    input logic                clk,
    input logic                rst_n,
    input logic [IN_W-1:0]     sensor_word,
    input logic [SAMPLE_W-1:0] sample_field,
    input logic [3:0]          bcd_ones,
    input logic [3:0]          bcd_tens,
    input logic [3:0]          bcd_hundreds,
    input logic [3:0]          bcd_thousands,
    input logic                mag_negative
);

    localparam int HALF = 1 << (SAMPLE_W - 1);
    localparam int FULL = 1 << SAMPLE_W;
    localparam int MULT = 1 << SCALE_SHIFT;

    int  shown_val;
    int  code;
    logic armed;

    always_comb begin
        shown_val = int'(bcd_ones) + 10 * int'(bcd_tens)
                  + 100 * int'(bcd_hundreds) + 1000 * int'(bcd_thousands);
        code = int'(sample_field);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R3
    a_r3_positive_value: assert property (@(posedge clk) disable iff (!rst_n)
        !sample_field[SAMPLE_W-1] |-> (shown_val == MULT * code) && !mag_negative);

    // R4
    a_r4_negative_value: assert property (@(posedge clk) disable iff (!rst_n)
        (sample_field[SAMPLE_W-1] && code != HALF)
            |-> (shown_val == MULT * (FULL - code)) && mag_negative);

    // R5
    a_r5_min_code_zero: assert property (@(posedge clk) disable iff (!rst_n)
        (code == HALF) |-> (shown_val == 0) && !mag_negative);

    // R6
    a_r6_digit_range: assert property (@(posedge clk) disable iff (!rst_n)
        (bcd_ones <= 4'd9) && (bcd_tens <= 4'd9)
            && (bcd_hundreds <= 4'd9) && (bcd_thousands <= 4'd2));

    if (OUT_REG) begin : g_lat
        // R7
        a_r7_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
            armed |-> sample_field == $past(sensor_word[SAMPLE_W-1:0]));
    end

endmodule

bind signed_sample_bcd signed_sample_bcd_chk #(
    .IN_W       (IN_W),
    .SAMPLE_W   (SAMPLE_W),
    .SCALE_SHIFT(SCALE_SHIFT),
    .OUT_REG    (OUT_REG)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .sensor_word  (sensor_word),
    .sample_field (sample_field),
    .bcd_ones     (bcd_ones),
    .bcd_tens     (bcd_tens),
    .bcd_hundreds (bcd_hundreds),
    .bcd_thousands(bcd_thousands),
    .mag_negative (mag_negative)
);

// File: tb/test_signed_sample_bcd.sv
module test_signed_sample_bcd;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] sensor_word = 16'h0000;
    logic [9:0]  sample_field;
    logic [3:0]  bcd_ones, bcd_tens, bcd_hundreds, bcd_thousands;
    logic        mag_negative;

    int n_cmp = 0;
    int n_bad = 0;

    always #4 clk = ~clk;

    signed_sample_bcd i_signed_sample_bcd (
        .clk          (clk),
        .rst_n        (rst_n),
        .sensor_word  (sensor_word),
        .sample_field (sample_field),
        .bcd_ones     (bcd_ones),
        .bcd_tens     (bcd_tens),
        .bcd_hundreds (bcd_hundreds),
        .bcd_thousands(bcd_thousands),
        .mag_negative (mag_negative)
    );

    // {word, expected decimal value, expected sign}
    localparam int NVEC = 14;
    localparam logic [28:0] VEC [NVEC] = '{
        {16'h0000, 12'd0,    1'b0},   // R3 zero
        {16'h0001, 12'd4,    1'b0},   // R3
        {16'h0019, 12'd100,  1'b0},   // R3
        {16'h00FA, 12'd1000, 1'b0},   // R3
        {16'h01FF, 12'd2044, 1'b0},   // R3 / R6 largest
        {16'h0200, 12'd0,    1'b0},   // R5
        {16'h0201, 12'd2044, 1'b1},   // R4
        {16'h03FF, 12'd4,    1'b1},   // R4
        {16'h0300, 12'd1024, 1'b1},   // R4
        {16'hFC05, 12'd20,   1'b0},   // R1
        {16'hA5FF, 12'd2044, 1'b0},   // R1
        {16'h7E00, 12'd0,    1'b0},   // R5 with upper bits set
        {16'h0164, 12'd1424, 1'b0},   // R3
        {16'h029C, 12'd1424, 1'b1}    // R4
    };

    function automatic int expected_value(int c);
        if (c < 512)       return 4 * c;
        else if (c == 512) return 0;
        else               return 2048 - 4 * (c - 512);
    endfunction

    task automatic check(string req, int act, int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic expect_out(string req, logic [15:0] w, int value, bit neg);
        check({req, " ones"},      int'(bcd_ones),      value % 10);
        check({req, " tens"},      int'(bcd_tens),      (value / 10) % 10);
        check({req, " hundreds"},  int'(bcd_hundreds),  (value / 100) % 10);
        check({req, " thousands"}, int'(bcd_thousands), value / 1000);
        check({req, " sign"},      int'(mag_negative),  int'(neg));
        check("R2 field",          int'(sample_field),  int'(w[9:0]));
        check("R6 range", int'(bcd_thousands <= 4'd2 && bcd_hundreds <= 4'd9
                              && bcd_tens <= 4'd9 && bcd_ones <= 4'd9), 1);
    endtask

    task automatic apply(logic [15:0] w);
        @(negedge clk);
        sensor_word = w;
        @(negedge clk);
    endtask

    initial begin
        // R8: reset holds everything at zero, even with a live input
        sensor_word = 16'hFFFF;
        repeat (3) @(negedge clk);
        check("R8 field", int'(sample_field), 0);
        check("R8 digits", int'({bcd_thousands, bcd_hundreds, bcd_tens, bcd_ones}), 0);
        check("R8 sign", int'(mag_negative), 0);
        sensor_word = 16'h0000;
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R7: new input is not visible before the next rising edge
        sensor_word = 16'h0019;
        #2;
        check("R7 before edge", int'(sample_field), 0);
        @(negedge clk);
        check("R7 after edge", int'(sample_field), 25);
        expect_out("R7 value", 16'h0019, 100, 1'b0);

        // Vector table
        for (int i = 0; i < NVEC; i++) begin
            apply(VEC[i][28:13]);
            expect_out("R3/R4/R5 table", VEC[i][28:13], int'(VEC[i][12:1]), VEC[i][0]);
        end

        // R1: upper bits changed, lower bits held
        begin
            logic [15:0] ref_out;
            apply(16'h0123);
            ref_out = {bcd_thousands, bcd_hundreds, bcd_tens, bcd_ones};
            apply(16'hDD23);
            check("R1 digits unchanged", int'({bcd_thousands, bcd_hundreds, bcd_tens, bcd_ones}),
                  int'(ref_out));
            check("R1 sign unchanged", int'(mag_negative), 0);
        end

        // Full sweep of all codes with varying upper bits
        for (int c = 0; c < 1024; c++) begin
            logic [15:0] w;
            w = {6'((c * 37) & 63), 10'(c)};
            apply(w);
            expect_out(c < 512 ? "R3 sweep" : (c == 512 ? "R5 sweep" : "R4 sweep"),
                       w, expected_value(c), (c > 512));
        end

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_cmp++;
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule